// File: doc/BRIEF.md
# Windowed Deadman Timer

This block is a deadman timer with a service window, placed on a simple synchronous register bus. Once software enables it, an internal counter advances by one every clock. Near the end of each period a service window opens. Software proves it is alive with a two-step key sequence:

- an arming key goes into one register;
- a release key goes into a second register, and it is accepted only while the window is open.

A correct sequence restarts the count. A wrong key, a release with no arming step, or a release outside the window does not restart the count. Each of these sets an error flag that software can read back.

If the count reaches the end of the period without a valid service, the block sets a timeout event flag and raises a reset request for exactly one clock. It also sets a sticky reset-cause bit that outlives disabling the timer. Software clears that bit explicitly. The period and window lengths are fixed by parameters and can be read on the bus, so software can derive the timeout in seconds from the clock rate. Writes are registered on the clock edge. Read data is a combinational function of the address.

Top module: `deadman_wdt`

## Requirements
- R1: After reset the timer is disabled. The counter (offset 0x40), the status register (0x30) and the reset-cause register (0x50) all read 0. Offset 0x60 reads PERIOD and offset 0x70 reads WINDOW. The outputs `timeout_evt` and `reset_req` are low.
- R2: Writing 1 to bit 15 of the control register (0x00) starts the timer; control reads bit 15 as the enable state. The counter then advances by one on every clock from 0 and never reaches PERIOD.
- R3: Status bit 0 is 1 exactly while the timer is enabled and the counter is at least PERIOD−WINDOW.
- R4: A service restarts the counter and leaves the error flags clear. It takes two writes in order:
  - 0x40 in bits 15:8 at offset 0x10 (the arming key);
  - then, while the window is open, 0x08 in bits 7:0 at offset 0x20 (the release key).
  The counter becomes 0 on the edge of the second write.
- R5: If the counter is at PERIOD−1 on an edge with no valid service, that edge does four things:
  - sets the event flag (status bit 5 and `timeout_evt`);
  - drives `reset_req` high for exactly one cycle;
  - restarts the counter at 0;
  - leaves the timer running.
- R6: A timeout sets bit 5 of the reset-cause register (0x50) and the `cause_flag` output. The bit stays set when the timer is disabled. Writing 1 to bit 5 of 0x50 clears it, and a timeout in the same cycle wins.
- R7: Writing any other value to bits 15:8 at 0x10 sets status bit 7 and does not arm the sequence.
- R8: Status bit 6 is set, and the counter keeps advancing, when a write to 0x20 does any of the following:
  - carries a wrong value;
  - comes with no accepted arming key;
  - comes while the window is closed.
- R9: Writing 0 to bit 15 of control stops the timer and returns the counter to 0. It clears status bits 5, 6 and 7, clears `timeout_evt` and drops any pending arming key.
- R10: Every bus write in the cycle right after a disabling write is ignored.
- R11: Key writes (0x10, 0x20) while the timer is disabled are ignored and set no flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_we | input | 1 | Write strobe, sampled on the rising edge |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr` (combinational) |
| timeout_evt | output | 1 | Timeout event flag, held until the timer is disabled |
| reset_req | output | 1 | One-cycle reset request on timeout |
| cause_flag | output | 1 | Sticky reset-cause bit |

## Verification
The bench probes the window edges one count apart. A design with an off-by-one open threshold shows status bit 0 a cycle early or late. The bench also times the expiry edge against the enabling write, so a counter that expires one edge early or late, or holds the reset request for two cycles, is caught.

The release key is sent three illegal ways: too early, with no arming key, and with a wrong value. In each case the counter must keep running, so a design that clears it anyway, or that sets no error flag, is exposed. A re-enable is written in the cycle straight after a disable, and it must not take effect. The reset-cause bit must also survive a disable, which catches a design that clears it together with the status flags.

// File: rtl/dmw_pkg.sv
package dmw_pkg;

    // Register byte offsets.
    localparam logic [7:0] OFS_CTRL  = 8'h00;
    localparam logic [7:0] OFS_ARM   = 8'h10;
    localparam logic [7:0] OFS_REL   = 8'h20;
    localparam logic [7:0] OFS_STAT  = 8'h30;
    localparam logic [7:0] OFS_COUNT = 8'h40;
    localparam logic [7:0] OFS_CAUSE = 8'h50;
    localparam logic [7:0] OFS_PER   = 8'h60;
    localparam logic [7:0] OFS_WIN   = 8'h70;

    // Field positions and key values.
    localparam int         EN_POS    = 15;
    localparam int         ST_OPEN   = 0;
    localparam int         ST_EVT    = 5;
    localparam int         ST_BADREL = 6;
    localparam int         ST_BADARM = 7;
    localparam int         CAUSE_POS = 5;
    localparam logic [7:0] ARM_KEY   = 8'h40;
    localparam logic [7:0] REL_KEY   = 8'h08;

    // Decoded write strobes.
    typedef struct packed {
        logic ctrl_we;
        logic en_val;
        logic arm_we;
        logic arm_ok;
        logic rel_we;
        logic rel_ok;
        logic cause_clr;
    } dmw_wr_t;

endpackage

// File: rtl/dmw_bus_dec.sv
module dmw_bus_dec
    import dmw_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32
) (
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              guard,
    output dmw_wr_t           wr
);

    // Writes are accepted only outside the guard cycle.
    logic live_we;

    always_comb begin
        live_we      = bus_we && !guard;
        wr           = '0;
        wr.ctrl_we   = live_we && (bus_addr == ADDR_W'(OFS_CTRL));
        wr.en_val    = bus_wdata[EN_POS];
        wr.arm_we    = live_we && (bus_addr == ADDR_W'(OFS_ARM));
        wr.arm_ok    = (bus_wdata[15:8] == ARM_KEY);
        wr.rel_we    = live_we && (bus_addr == ADDR_W'(OFS_REL));
        wr.rel_ok    = (bus_wdata[7:0] == REL_KEY);
        wr.cause_clr = live_we && (bus_addr == ADDR_W'(OFS_CAUSE))
                       && bus_wdata[CAUSE_POS];
    end

endmodule

// File: rtl/dmw_counter.sv
module dmw_counter #(
    parameter int CNT_W  = 32,
    parameter int PERIOD = 64,
    parameter int WINDOW = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             clear_all,
    input  logic             service,
    output logic [CNT_W-1:0] cnt,
    output logic             win_open,
    output logic             expire
);

    localparam logic [CNT_W-1:0] OPEN_AT  = CNT_W'(PERIOD - WINDOW);
    localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(PERIOD - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_q, st_d;

    always_comb begin
        st_d     = st_q;
        win_open = enable && (st_q.cnt >= OPEN_AT);
        expire   = enable && !clear_all && !service && (st_q.cnt == LAST_CNT);

        if (clear_all || !enable || service || expire) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt = st_q.cnt;

endmodule

// File: rtl/dmw_keyseq.sv
module dmw_keyseq
    import dmw_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    enable,
    input  logic    clear_all,
    input  logic    expire,
    input  logic    win_open,
    input  dmw_wr_t wr,
    output logic    service,
    output logic    bad_arm,
    output logic    bad_rel
);

    typedef struct packed {
        logic armed;
        logic bad_arm;
        logic bad_rel;
    } key_state_t;

    key_state_t st_q, st_d;

    always_comb begin
        st_d    = st_q;
        service = enable && wr.rel_we && wr.rel_ok && st_q.armed && win_open;

        if (clear_all) begin
            st_d = '0;
        end else if (enable) begin
            if (wr.arm_we) begin
                if (wr.arm_ok) begin
                    st_d.armed = 1'b1;
                end else begin
                    st_d.armed   = 1'b0;
                    st_d.bad_arm = 1'b1;
                end
            end
            if (wr.rel_we) begin
                st_d.armed = 1'b0;
                if (!service) begin
                    st_d.bad_rel = 1'b1;
                end
            end
            if (expire) begin
                st_d.armed = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bad_arm = st_q.bad_arm;
    assign bad_rel = st_q.bad_rel;

endmodule

// File: rtl/deadman_wdt.sv
module deadman_wdt
    import dmw_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 32,
    parameter int PERIOD = 64,
    parameter int WINDOW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              timeout_evt,
    output logic              reset_req,
    output logic              cause_flag
);

    typedef struct packed {
        logic enable;
        logic guard;
        logic evt;
        logic cause;
        logic req;
    } top_state_t;

    top_state_t       st_q, st_d;
    dmw_wr_t          wr;
    logic             clear_all;
    logic             service;
    logic             expire;
    logic             win_open;
    logic             bad_arm;
    logic             bad_rel;
    logic [CNT_W-1:0] cnt;
    logic             enable_q;

    dmw_bus_dec #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .guard     (st_q.guard),
        .wr        (wr)
    );

    dmw_counter #(.CNT_W(CNT_W), .PERIOD(PERIOD), .WINDOW(WINDOW)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (st_q.enable),
        .clear_all (clear_all),
        .service   (service),
        .cnt       (cnt),
        .win_open  (win_open),
        .expire    (expire)
    );

    dmw_keyseq u_key (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (st_q.enable),
        .clear_all (clear_all),
        .expire    (expire),
        .win_open  (win_open),
        .wr        (wr),
        .service   (service),
        .bad_arm   (bad_arm),
        .bad_rel   (bad_rel)
    );

    always_comb begin
        clear_all = wr.ctrl_we && !wr.en_val;
        st_d      = st_q;
        st_d.req  = expire;
        st_d.guard = clear_all;

        if (wr.ctrl_we) begin
            st_d.enable = wr.en_val;
        end

        if (clear_all) begin
            st_d.evt = 1'b0;
        end else if (expire) begin
            st_d.evt = 1'b1;
        end

        if (expire) begin
            st_d.cause = 1'b1;
        end else if (wr.cause_clr) begin
            st_d.cause = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // Combinational read mux.
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(OFS_CTRL)) begin
            bus_rdata[EN_POS] = st_q.enable;
        end else if (bus_addr == ADDR_W'(OFS_STAT)) begin
            bus_rdata[ST_OPEN]   = win_open;
            bus_rdata[ST_EVT]    = st_q.evt;
            bus_rdata[ST_BADREL] = bad_rel;
            bus_rdata[ST_BADARM] = bad_arm;
        end else if (bus_addr == ADDR_W'(OFS_COUNT)) begin
            bus_rdata = DATA_W'(cnt);
        end else if (bus_addr == ADDR_W'(OFS_CAUSE)) begin
            bus_rdata[CAUSE_POS] = st_q.cause;
        end else if (bus_addr == ADDR_W'(OFS_PER)) begin
            bus_rdata = DATA_W'(PERIOD);
        end else if (bus_addr == ADDR_W'(OFS_WIN)) begin
            bus_rdata = DATA_W'(WINDOW);
        end
    end

    assign enable_q    = st_q.enable;
    assign timeout_evt = st_q.evt;
    assign reset_req   = st_q.req;
    assign cause_flag  = st_q.cause;

endmodule

// File: rtl/deadman_wdt_chk.sv
module deadman_wdt_chk #(
    parameter int CNT_W  = 32,
    parameter int PERIOD = 64
) (
    input logic             clk,
    input logic             rst_n,
    input logic             enable,
    input logic             evt,
    input logic             req,
    input logic             service,
    input logic             bad_arm,
    input logic             bad_rel,
    input logic [CNT_W-1:0] cnt
);

    AST_CNT_BELOW_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        cnt < CNT_W'(PERIOD)); // R2

    AST_SERVICE_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
        service |=> (cnt == '0)); // R4

    AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> !req); // R5

    AST_REQ_WITH_EVT: assert property (@(posedge clk) disable iff (!rst_n)
        req |-> evt); // R5

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |-> (!evt && !bad_arm && !bad_rel && cnt == '0)); // R9

    AST_GUARD_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(enable) |=> !enable); // R10

endmodule

bind deadman_wdt deadman_wdt_chk #(.CNT_W(CNT_W), .PERIOD(PERIOD)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .enable  (enable_q),
    .evt     (timeout_evt),
    .req     (reset_req),
    .service (service),
    .bad_arm (bad_arm),
    .bad_rel (bad_rel),
    .cnt     (cnt)
);

// File: tb/deadman_wdt_test.sv
`timescale 1ns/100ps
module deadman_wdt_test;

    localparam int PER = 64;
    localparam int WIN = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        timeout_evt, reset_req, cause_flag;
    int          n_chk = 0;
    int          n_fail = 0;

    always #2 clk = ~clk;

    deadman_wdt uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .timeout_evt(timeout_evt), .reset_req(reset_req), .cause_flag(cause_flag)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #0.2;
        d = bus_rdata;
    endtask

    task automatic wait_cnt(input int target);
        logic [31:0] v;
        for (int i = 0; i < 1000; i++) begin
            rd(8'h40, v);
            if (v == target) break;
            @(negedge clk);
        end
    endtask

    task automatic restart();
        wr(8'h00, 32'h0);
        @(negedge clk);
        wr(8'h00, 32'h8000);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(8'h40, v); check("R1 count", v, 0);
        rd(8'h30, v); check("R1 status", v, 0);
        rd(8'h50, v); check("R1 cause", v, 0);
        rd(8'h60, v); check("R1 period", v, PER);
        rd(8'h70, v); check("R1 window", v, WIN);
        check("R1 outputs", {timeout_evt, reset_req, cause_flag}, 0);
    endtask

    task automatic t_count();
        logic [31:0] v;
        wr(8'h00, 32'h8000);
        rd(8'h00, v); check("R2 ctrl", v, 32'h8000);
        repeat (5) @(negedge clk);
        rd(8'h40, v); check("R2 count", v, 5);
    endtask

    task automatic t_window();
        logic [31:0] v;
        restart();
        wait_cnt(PER - WIN - 1);
        rd(8'h30, v); check("R3 closed", v[0], 0);
        @(negedge clk);
        rd(8'h30, v); check("R3 open", v[0], 1);
    endtask

    task automatic t_service();
        logic [31:0] v;
        restart();
        wait_cnt(50);
        wr(8'h10, 32'h4000);
        wr(8'h20, 32'h08);
        rd(8'h40, v); check("R4 count", v, 0);
        rd(8'h30, v); check("R4 status", v, 0);
    endtask

    task automatic t_expire();
        logic [31:0] v;
        restart();
        repeat (PER - 1) @(negedge clk);
        rd(8'h40, v); check("R5 last count", v, PER - 1);
        check("R5 no req yet", reset_req, 0);
        @(negedge clk);
        check("R5 req", reset_req, 1);
        check("R5 evt", timeout_evt, 1);
        rd(8'h40, v); check("R5 restart", v, 0);
        @(negedge clk);
        check("R5 req width", reset_req, 0);
        rd(8'h30, v); check("R5 status evt", v[5], 1);
        rd(8'h50, v); check("R6 cause set", v, 32'h20);
    endtask

    task automatic t_disable_cause();
        logic [31:0] v;
        wr(8'h10, 32'h1100);
        wr(8'h00, 32'h0);
        rd(8'h30, v); check("R9 status cleared", v, 0);
        rd(8'h40, v); check("R9 count cleared", v, 0);
        check("R9 evt low", timeout_evt, 0);
        rd(8'h50, v); check("R6 cause kept", v, 32'h20);
        @(negedge clk);
        wr(8'h50, 32'h20);
        rd(8'h50, v); check("R6 cause cleared", v, 0);
        check("R6 cause pin", cause_flag, 0);
    endtask

    task automatic t_bad_keys();
        logic [31:0] v;
        logic [31:0] c;
        restart();
        wr(8'h10, 32'h4100);
        rd(8'h30, v); check("R7 bad arm", v[7:5], 3'b100);
        restart();
        rd(8'h40, c);
        wr(8'h10, 32'h4000);
        wr(8'h20, 32'h08);
        rd(8'h30, v); check("R8 early rel", v[7:5], 3'b010);
        rd(8'h40, v); check("R8 early count runs", v, c + 2);
        restart();
        wait_cnt(52);
        wr(8'h20, 32'h08);
        rd(8'h30, v); check("R8 unarmed rel", v[7:5], 3'b010);
        rd(8'h40, v); check("R8 unarmed count runs", v, 53);
        restart();
        wait_cnt(52);
        wr(8'h10, 32'h4000);
        wr(8'h20, 32'h09);
        rd(8'h30, v); check("R8 wrong rel", v[7:5], 3'b010);
        rd(8'h40, v); check("R8 wrong count runs", v, 54);
    endtask

    task automatic t_guard_idle();
        logic [31:0] v;
        wr(8'h00, 32'h0);
        wr(8'h00, 32'h8000);
        repeat (3) @(negedge clk);
        rd(8'h00, v); check("R10 ignored enable", v, 0);
        rd(8'h40, v); check("R10 count idle", v, 0);
        wr(8'h10, 32'h1200);
        wr(8'h20, 32'h77);
        rd(8'h30, v); check("R11 idle keys", v, 0);
        wr(8'h00, 32'h8000);
        rd(8'h00, v); check("R10 later enable", v, 32'h8000);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_count();
        t_window();
        t_service();
        t_expire();
        t_disable_cause();
        t_bad_keys();
        t_guard_idle();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule